// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Router

This block collects the level interrupt requests of a small set of bus devices, each with four interrupt pins (INTA..INTD), and presents them as a 16-line legacy interrupt level vector. Each pin is first rotated by the slot of its device onto one of four shared lines. The same pin on neighbouring slots therefore lands on different shared lines, which spreads the load. Every shared line then passes through a byte-wide steering register. That register either names a legacy IRQ number or leaves the line disconnected.

Several shared lines may be steered to the same IRQ. The IRQ output is then the OR of all of them. Firmware programs the steering registers through a simple write port: a line index and a data byte. The shared-line levels are latched once and the IRQ vector is registered once more, so the outputs never glitch. A change on a device pin reaches the IRQ vector two clock edges later. A steering write reaches it one edge after the write edge.

Top module: `pirq_router`

## Requirements
- R1: A device's slot is its devfn value shifted right by 3 (function bits ignored). Pin p (0 = INTA .. 3 = INTD) of that device drives shared line (p + slot - 1) mod 4, where lines 0..3 are A..D.
- R2: A shared line's level is the OR of every device pin that rotates onto it. The level is latched at the next rising clock edge.
- R3: Reset sets all four steering registers to 0x80, so every line is disconnected and `irq_out` is all zero after reset.
- R4: A write with `cfg_wr_en` high loads `cfg_wr_data` into the steering register selected by `cfg_wr_idx` (0..3 = line A..D) at the clock edge, and touches no other line.
- R5: A steering value from 0 to 15 connects the line to the `irq_out` bit with that index, including both ends, 0 and 15.
- R6: A steering value of 16 or more leaves the line disconnected, whatever the line's level.
- R7: When several lines are steered to the same IRQ, that IRQ bit is the OR of their levels.
- R8: Any `irq_out` bit selected by no steering register is driven to zero.
- R9: `irq_out` is registered. A pin change becomes visible two rising edges after it is driven, and the value one edge after the change is still the old one. A steering write becomes visible one edge after the write edge.
- R10: Reset clears the latched shared-line levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_req | input | N_DEV*4 | Pin levels; bit d*4+p is pin p of device d |
| cfg_wr_en | input | 1 | Steering register write strobe |
| cfg_wr_idx | input | log2(N_LINES) | Shared line whose steering register is written |
| cfg_wr_data | input | ROUTE_W | Steering value; below N_IRQ selects that IRQ |
| irq_out | output | N_IRQ | Registered legacy IRQ levels |

## Verification
On every cycle, assertions check the following. A write lands in the addressed steering register. A latched line is never high unless some pin was high the cycle before. No IRQ bit rises without a steering register selecting it. A vector whose lines are all disconnected stays silent. No more IRQs are active than there are lines. The exact rotation of each slot and pin, the sharing of one IRQ by two lines, the two-edge pin latency and the reset of state in the middle of a run are shown only by the bench's scenarios. Its scoreboard compares the whole vector against a model built from the requirements.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

   localparam int unsigned PINS_PER_DEV = 4;

   // Shared line reached by pin 'pin' of the device at 'devfn'
   function automatic int unsigned line_of(input int unsigned devfn,
                                           input int unsigned pin,
                                           input int unsigned n_lines);
      int unsigned slot;
      slot = devfn >> 3;
      return (pin + slot + n_lines - 1) % n_lines;
   endfunction

   // Mask of a device's pins that rotate onto line 'ln'
   function automatic logic [PINS_PER_DEV-1:0] pin_mask(input int unsigned devfn,
                                                        input int unsigned ln,
                                                        input int unsigned n_lines);
      logic [PINS_PER_DEV-1:0] m;
      m = '0;
      for (int unsigned p = 0; p < PINS_PER_DEV; p++)
         if (line_of(devfn, p, n_lines) == ln) m[p] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
   import pirq_pkg::*;
#(
   parameter int unsigned N_DEV      = 4,
   parameter int unsigned N_LINES    = 4,
   parameter logic [N_DEV*8-1:0] DEVFN_LIST = '0
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_DEV*PINS_PER_DEV-1:0] dev_req,
   output logic [N_LINES-1:0]            line_lvl
);

   localparam int unsigned REQ_W = N_DEV * PINS_PER_DEV;

   initial begin
      if (N_DEV < 1)   $error("pirq_swizzle: N_DEV must be at least 1");
      if (N_LINES < 2) $error("pirq_swizzle: N_LINES must be at least 2");
   end

   logic [N_LINES-1:0] contrib [N_DEV];
   logic [N_LINES-1:0] line_next;

   for (genvar d = 0; d < N_DEV; d++) begin : g_dev
      localparam int unsigned DEVFN = int'(DEVFN_LIST[d*8 +: 8]);
      for (genvar l = 0; l < N_LINES; l++) begin : g_line
         localparam logic [PINS_PER_DEV-1:0] MASK = pin_mask(DEVFN, l, N_LINES);
         assign contrib[d][l] = |(dev_req[d*PINS_PER_DEV +: PINS_PER_DEV] & MASK);
      end
   end

   always_comb begin
      line_next = '0;
      for (int d = 0; d < int'(N_DEV); d++)
         line_next = line_next | contrib[d];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_lvl <= '0;
      else        line_lvl <= line_next;
   end

   AST_LINE_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (line_lvl != '0) |-> ($past(dev_req) != {REQ_W{1'b0}})); // R2

endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs #(
   parameter int unsigned N_LINES     = 4,
   parameter int unsigned ROUTE_W     = 8,
   parameter logic [ROUTE_W-1:0] RESET_ROUTE = 8'h80
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [$clog2(N_LINES)-1:0]  wr_idx,
   input  logic [ROUTE_W-1:0]          wr_data,
   output logic [N_LINES*ROUTE_W-1:0]  route_flat
);

   localparam int unsigned IDX_W = $clog2(N_LINES);

   initial begin
      if (ROUTE_W < 1 || ROUTE_W > 16) $error("pirq_route_regs: ROUTE_W out of range");
   end

   for (genvar l = 0; l < N_LINES; l++) begin : g_reg
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(l);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            route_flat[l*ROUTE_W +: ROUTE_W] <= RESET_ROUTE;
         else if (wr_en && wr_idx == MY_IDX)
            route_flat[l*ROUTE_W +: ROUTE_W] <= wr_data;
      end
   end

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (int'(wr_idx) < int'(N_LINES))) |=>
      (route_flat[$past(wr_idx)*ROUTE_W +: ROUTE_W] == $past(wr_data))); // R4

endmodule

// File: rtl/pirq_merge.sv
module pirq_merge #(
   parameter int unsigned N_LINES      = 4,
   parameter int unsigned ROUTE_W      = 8,
   parameter int unsigned N_IRQ        = 16,
   parameter bit          REGISTER_OUT = 1'b1
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_LINES-1:0]         line_lvl,
   input  logic [N_LINES*ROUTE_W-1:0] route_flat,
   output logic [N_IRQ-1:0]           irq_out
);

   initial begin
      if (N_IRQ < 1 || N_IRQ > (1 << ROUTE_W))
         $error("pirq_merge: N_IRQ must fit the steering value width");
   end

   logic [N_IRQ-1:0] hit;
   logic [N_IRQ-1:0] sel_mask;

   for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
      localparam logic [ROUTE_W-1:0] MY_NUM = ROUTE_W'(i);
      logic [N_LINES-1:0] match;
      for (genvar l = 0; l < N_LINES; l++) begin : g_ln
         assign match[l] = (route_flat[l*ROUTE_W +: ROUTE_W] == MY_NUM);
      end
      assign sel_mask[i] = |match;
      assign hit[i]      = |(match & line_lvl);
   end

   if (REGISTER_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_out <= '0;
         else        irq_out <= hit;
      end

      AST_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_out & ~$past(sel_mask)) == '0); // R8
      AST_UNROUTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(sel_mask) == '0) |-> (irq_out == '0)); // R6
      AST_SOURCE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_out != '0) |-> ($past(line_lvl) != '0)); // R9
      AST_FANIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(irq_out) <= N_LINES); // R7
   end else begin : g_comb_out
      assign irq_out = hit;
   end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
   import pirq_pkg::*;
#(
   parameter int unsigned N_DEV        = 4,
   parameter int unsigned N_LINES      = 4,
   parameter int unsigned N_IRQ        = 16,
   parameter int unsigned ROUTE_W      = 8,
   parameter logic [ROUTE_W-1:0] RESET_ROUTE = 8'h80,
   parameter bit          REGISTER_OUT = 1'b1,
   parameter logic [N_DEV*8-1:0] DEVFN_LIST = {8'h20, 8'h18, 8'h10, 8'h08}
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_DEV*4-1:0]            dev_req,
   input  logic                          cfg_wr_en,
   input  logic [$clog2(N_LINES)-1:0]    cfg_wr_idx,
   input  logic [ROUTE_W-1:0]            cfg_wr_data,
   output logic [N_IRQ-1:0]              irq_out
);

   initial begin
      if (PINS_PER_DEV != 4) $error("pirq_router: four pins per device expected");
      if (RESET_ROUTE < ROUTE_W'(N_IRQ))
         $error("pirq_router: reset steering value must leave lines disconnected");
   end

   logic [N_LINES-1:0]         line_lvl;
   logic [N_LINES*ROUTE_W-1:0] route_flat;

   pirq_swizzle #(
      .N_DEV      (N_DEV),
      .N_LINES    (N_LINES),
      .DEVFN_LIST (DEVFN_LIST)
   ) i_swizzle (
      .clk      (clk),
      .rst_n    (rst_n),
      .dev_req  (dev_req),
      .line_lvl (line_lvl)
   );

   pirq_route_regs #(
      .N_LINES     (N_LINES),
      .ROUTE_W     (ROUTE_W),
      .RESET_ROUTE (RESET_ROUTE)
   ) i_route_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_wr_en),
      .wr_idx     (cfg_wr_idx),
      .wr_data    (cfg_wr_data),
      .route_flat (route_flat)
   );

   pirq_merge #(
      .N_LINES      (N_LINES),
      .ROUTE_W      (ROUTE_W),
      .N_IRQ        (N_IRQ),
      .REGISTER_OUT (REGISTER_OUT)
   ) i_merge (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_lvl   (line_lvl),
      .route_flat (route_flat),
      .irq_out    (irq_out)
   );

   AST_RESET_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_out == '0)); // R3

endmodule

// File: tb/test_pirq_router.sv
module test_pirq_router;

   localparam int N_DEV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] dev_req = '0;
   logic        cfg_wr_en = 1'b0;
   logic [1:0]  cfg_wr_idx = '0;
   logic [7:0]  cfg_wr_data = '0;
   logic [15:0] irq_out;

   always #5 clk = ~clk;

   pirq_router #(
      .DEVFN_LIST ({8'h20, 8'h1A, 8'h10, 8'h08})
   ) i_pirq_router (
      .clk         (clk),
      .rst_n       (rst_n),
      .dev_req     (dev_req),
      .cfg_wr_en   (cfg_wr_en),
      .cfg_wr_idx  (cfg_wr_idx),
      .cfg_wr_data (cfg_wr_data),
      .irq_out     (irq_out)
   );

   typedef struct {
      logic [15:0] exp;
      int          due;
      string       tag;
   } item_t;

   item_t q[$];
   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int unsigned devfn_m [N_DEV] = '{8'h08, 8'h10, 8'h1A, 8'h20};
   logic [7:0]  m_route [4];
   logic [15:0] cur_req = '0;

   always @(posedge clk) cyc = cyc + 1;

   function automatic logic [15:0] model_out(input logic [15:0] req);
      logic [3:0]  ln;
      logic [15:0] o;
      ln = '0;
      o  = '0;
      for (int d = 0; d < N_DEV; d++)
         for (int p = 0; p < 4; p++)
            if (req[d*4+p]) ln[(p + (devfn_m[d] >> 3) + 3) % 4] = 1'b1;
      for (int l = 0; l < 4; l++)
         if (ln[l] && m_route[l] < 8'd16) o[m_route[l][3:0]] = 1'b1;
      return o;
   endfunction

   task automatic push(input logic [15:0] exp, input int due, input string tag);
      item_t it;
      it.exp = exp; it.due = due; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic drain();
      wait (q.size() == 0);
      @(negedge clk);
   endtask

   // Scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0 && cyc >= q[0].due) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (irq_out !== it.exp) begin
               errors++;
               $display("FAIL %s: irq_out=%h expected=%h", it.tag, irq_out, it.exp);
            end
         end
      end
   end

   task automatic set_pins(input logic [15:0] req, input string tag);
      logic [15:0] old_exp;
      @(negedge clk);
      old_exp = model_out(cur_req);
      dev_req = req;
      cur_req = req;
      push(old_exp, cyc + 1, "R9 old value held one edge");
      push(model_out(req), cyc + 2, tag);
      drain();
   endtask

   task automatic wr_route(input int idx, input logic [7:0] val, input string tag);
      @(negedge clk);
      cfg_wr_en   = 1'b1;
      cfg_wr_idx  = 2'(idx);
      cfg_wr_data = val;
      m_route[idx] = val;
      push(model_out(cur_req), cyc + 2, tag);
      @(negedge clk);
      cfg_wr_en = 1'b0;
      drain();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: irq_out=%h expected=run completion", irq_out);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int l = 0; l < 4; l++) m_route[l] = 8'h80;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      push(16'h0000, cyc + 1, "R3 reset state");
      drain();

      // R3 R6: all pins high, every line still disconnected
      set_pins(16'hFFFF, "R3 R6 all lines unrouted after reset");
      set_pins(16'h0000, "R2 all pins low");

      wr_route(0, 8'd5,  "R4 R5 line A to irq5 while idle");
      wr_route(1, 8'd9,  "R4 line B to irq9");
      wr_route(2, 8'd15, "R4 line C to irq15");
      wr_route(3, 8'h10, "R4 R6 line D set to 16");

      set_pins(16'h0001, "R1 slot1 INTA to line A irq5");
      set_pins(16'h0010, "R1 slot2 INTA to line B irq9");
      set_pins(16'h0200, "R1 R6 devfn 0x1A INTB to line D unrouted");
      set_pins(16'h8000, "R1 R5 slot4 INTD to line C irq15");
      set_pins(16'hFFFF, "R8 only selected irqs active");
      set_pins(16'h2000, "R2 slot4 INTB reaches line A");
      set_pins(16'h2001, "R2 two pins on line A");
      set_pins(16'h2000, "R2 one pin dropped line A held");
      set_pins(16'h0000, "R2 line A released");

      // R7: two lines sharing irq5
      wr_route(1, 8'd5, "R7 line B to irq5");
      set_pins(16'h0001, "R7 line A alone on irq5");
      set_pins(16'h0010, "R7 line B alone on irq5");
      set_pins(16'h0011, "R7 both lines on irq5");
      set_pins(16'h0000, "R7 shared irq released");

      // R5 lower boundary, R6 upper values
      set_pins(16'h0200, "R6 line D still unrouted");
      wr_route(3, 8'd0,  "R5 line D to irq0 with pin held");
      wr_route(3, 8'hFF, "R6 line D value 0xFF disconnects");
      wr_route(2, 8'h1F, "R6 line C value 0x1F");
      set_pins(16'h8200, "R6 lines C D both unrouted");

      // R10 R3: reset in the middle of activity
      set_pins(16'hFFFF, "R8 full load before reset");
      @(negedge clk);
      rst_n = 1'b0;
      for (int l = 0; l < 4; l++) m_route[l] = 8'h80;
      @(negedge clk);
      checks++;
      if (irq_out !== 16'h0000) begin
         errors++;
         $display("FAIL R10 during reset: irq_out=%h expected=0000", irq_out);
      end
      rst_n = 1'b1;
      push(16'h0000, cyc + 2, "R3 R10 steering cleared by reset");
      drain();
      wr_route(1, 8'd3, "R10 R5 relatch after reset line B to irq3");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule